// File: doc/BRIEF.md
# Counter-Polled Bus Arbiter

This block decides which of up to `N_MASTERS` bus masters gets the shared bus next. The masters do not have their own request or grant wires. Every master drives one common request line, and whichever master owns the bus drives a common busy line.

When the arbiter is idle and it sees a request while the bus is free, it starts a polling sweep. Each clock it puts one device address on a small address bus and raises a strobe that marks the address as valid. A requesting master that sees its own address raises busy in that same cycle. The arbiter then stops counting and keeps the matched address on the bus for as long as busy stays high. If a sweep reaches every address once and nobody answers, the arbiter goes back to idle.

The address where a sweep starts sets the priority order. Three start policies are available:
- **Fixed:** always start at zero.
- **Rotating:** start just after the last winner.
- **Programmable:** start at a loaded value.

A small synchronous write port loads the start policy and the start value. The block moves no data, so all pins are plain control pins and there is no valid/ready handshake.

Top module: `arb_poll_top`

## Requirements
- R1: After reset, `poll_en` is low and `poll_addr` is 0. The start policy is fixed, the start value is 0, and the stored last winner is N_MASTERS-1.
- R2: In idle, a clock edge that samples `bus_req` high and `bus_busy` low starts a sweep, and `poll_en` is high from the next cycle. While `bus_busy` is sampled high in idle, no sweep starts.
- R3: While `poll_en` is high, `poll_addr` lies in 0..N_MASTERS-1. It moves on by one address per clock and wraps from N_MASTERS-1 to 0.
- R4: When `bus_busy` is sampled high during a sweep, `poll_en` is low from the next cycle. `poll_addr` then holds the matched address until `bus_busy` is sampled low, after which the arbiter is idle.
- R5: Policy code 0 (fixed) starts every sweep at address 0, so a lower address always wins over a higher one.
- R6: Policy code 1 (rotating) starts a sweep at the address after the last winner, modulo N_MASTERS. Every ownership updates the last winner, whatever the policy.
- R7: Policy code 2 (programmable) starts a sweep at the loaded start value. A start value of N_MASTERS or more starts the sweep at 0.
- R8: A sweep that shows all N_MASTERS addresses without `bus_busy` being sampled high lasts exactly N_MASTERS cycles and then returns to idle.
- R9: `cfg_mode_we` loads `cfg_mode` and `cfg_start_we` loads `cfg_start` at a clock edge. A write changes only sweeps that start after that edge, never a sweep already running.
- R10: Policy code 3 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Shared request line (OR of all masters) |
| bus_busy | input | 1 | Shared busy line, driven by the owner or by a master that matches during a sweep |
| cfg_mode_we | input | 1 | Write strobe for the start policy |
| cfg_mode | input | 2 | Start policy: 0 fixed, 1 rotating, 2 programmable, 3 same as 0 |
| cfg_start_we | input | 1 | Write strobe for the start value |
| cfg_start | input | AW | Start value for the programmable policy |
| poll_en | output | 1 | High while a sweep is running and `poll_addr` is being polled |
| poll_addr | output | AW | Polled address during a sweep, or the owner's address while the bus is held |

## Verification
The assertions assume that masters answer only through `bus_busy`, and that during a sweep `bus_busy` rises only when a master with a pending request matches `poll_addr`. They also assume that `bus_busy` stays low in the idle cycle after an owner releases the bus, unless an outside agent holds it on purpose.

The stimulus keeps to these rules by modelling each master in the bench:
- A master posts its request.
- It raises busy in the cycle its address is polled.
- It holds busy for a fixed number of cycles.
- It then drops both busy and its request together.

Only the dedicated idle-blocking case drives busy from outside, and it does so only while the arbiter is idle.

// File: rtl/arb_poll_pkg.sv
package arb_poll_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_ROTATE = 2'd1,
    MODE_PROG   = 2'd2,
    MODE_RSVD   = 2'd3
  } start_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_OWN  = 2'd2
  } poll_state_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_poll_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [1:0]    mode_in,
  input  logic          start_we,
  input  logic [AW-1:0] start_in,
  output start_mode_e   mode_q,
  output logic [AW-1:0] start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_FIXED;
      start_q <= '0;
    end else begin
      if (mode_we)  mode_q  <= start_mode_e'(mode_in);
      if (start_we) start_q <= start_in;
    end
  end
endmodule

// File: rtl/arb_start_sel.sv
module arb_start_sel
  import arb_poll_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int AW        = 3
) (
  input  start_mode_e   mode,
  input  logic [AW-1:0] start_val,
  input  logic [AW-1:0] last_win,
  output logic [AW-1:0] start_addr
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(N_MASTERS - 1);

  logic [AW-1:0] prog_addr;
  logic [AW-1:0] rot_addr;

  // Only a non-power-of-two master count can hold out-of-range start values
  generate
    if ((2 ** AW) == N_MASTERS) begin : g_no_clamp
      assign prog_addr = start_val;
    end else begin : g_clamp
      assign prog_addr = (int'(start_val) >= N_MASTERS) ? '0 : start_val;
    end
  endgenerate

  assign rot_addr = (last_win == LAST_ADDR) ? '0 : last_win + 1'b1;

  always_comb begin
    unique case (mode)
      MODE_ROTATE: start_addr = rot_addr;
      MODE_PROG:   start_addr = prog_addr;
      default:     start_addr = '0;
    endcase
  end
endmodule

// File: rtl/arb_poll_fsm.sv
module arb_poll_fsm
  import arb_poll_pkg::*;
#(
  parameter int N_MASTERS = 6,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_busy,
  input  logic [AW-1:0] start_addr,
  output logic          poll_en,
  output logic [AW-1:0] poll_addr,
  output logic [AW-1:0] last_win
);
  localparam logic [AW-1:0] LAST_ADDR  = AW'(N_MASTERS - 1);
  localparam logic [AW-1:0] SWEEP_LAST = AW'(N_MASTERS - 1);

  poll_state_e   state_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] sweep_q;
  logic [AW-1:0] win_q;
  logic [AW-1:0] addr_nxt;

  assign addr_nxt = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sweep_q <= '0;
      win_q   <= LAST_ADDR;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (bus_req && !bus_busy) begin
            state_q <= ST_POLL;
            addr_q  <= start_addr;
            sweep_q <= '0;
          end
        end
        ST_POLL: begin
          if (bus_busy) begin
            state_q <= ST_OWN;
            win_q   <= addr_q;
          end else if (sweep_q == SWEEP_LAST) begin
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= addr_nxt;
            sweep_q <= sweep_q + 1'b1;
          end
        end
        ST_OWN: begin
          if (!bus_busy) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign poll_en   = (state_q == ST_POLL);
  assign poll_addr = addr_q;
  assign last_win  = win_q;

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_en |-> (int'(poll_addr) < N_MASTERS)); // R3
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bus_req && !bus_busy) |=> poll_en); // R2
  AST_IDLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bus_busy) |=> !poll_en); // R2
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && !bus_busy && sweep_q != SWEEP_LAST) |=>
      (poll_en && poll_addr == (($past(poll_addr) == LAST_ADDR) ? '0 : $past(poll_addr) + 1'b1))); // R3
  AST_STOP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && bus_busy) |=> (!poll_en && $stable(poll_addr))); // R4
  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWN && bus_busy) |=> (!poll_en && $stable(poll_addr))); // R4
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && !bus_busy && sweep_q == SWEEP_LAST) |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/arb_poll_top.sv
module arb_poll_top
  import arb_poll_pkg::*;
#(
  parameter int N_MASTERS = 6,
  // derived width of the device-address bus; not meant to be overridden
  parameter int AW        = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_busy,
  input  logic          cfg_mode_we,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_start_we,
  input  logic [AW-1:0] cfg_start,
  output logic          poll_en,
  output logic [AW-1:0] poll_addr
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(N_MASTERS - 1);

  start_mode_e   mode_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] last_win;
  logic [AW-1:0] start_addr;

  arb_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mode_we(cfg_mode_we), .mode_in(cfg_mode),
    .start_we(cfg_start_we), .start_in(cfg_start),
    .mode_q(mode_q), .start_q(start_q)
  );

  arb_start_sel #(.N_MASTERS(N_MASTERS), .AW(AW)) u_sel (
    .mode(mode_q), .start_val(start_q), .last_win(last_win),
    .start_addr(start_addr)
  );

  arb_poll_fsm #(.N_MASTERS(N_MASTERS), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_busy(bus_busy),
    .start_addr(start_addr),
    .poll_en(poll_en), .poll_addr(poll_addr), .last_win(last_win)
  );

  AST_FIXED_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(poll_en) && ($past(mode_q) == MODE_FIXED || $past(mode_q) == MODE_RSVD))
      |-> (poll_addr == '0)); // R5 R10
  AST_ROTATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(poll_en) && $past(mode_q) == MODE_ROTATE)
      |-> (poll_addr == (($past(last_win) == LAST_ADDR) ? '0 : $past(last_win) + 1'b1))); // R6
  AST_PROG_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(poll_en) && $past(mode_q) == MODE_PROG && int'($past(start_q)) < N_MASTERS)
      |-> (poll_addr == $past(start_q))); // R7
endmodule

// File: tb/arb_poll_top_tb.sv
module arb_poll_top_tb_top;
  localparam int N    = 6;
  localparam int AW   = 3;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_mode_we = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_start_we = 1'b0;
  logic [AW-1:0] cfg_start = '0;
  logic          poll_en;
  logic [AW-1:0] poll_addr;
  logic          bus_req;
  logic          bus_busy;

  logic [2**AW-1:0] dev_req = '0;
  logic [2**AW-1:0] req_post = '0;
  logic [2**AW-1:0] req_kill = '0;
  logic             ext_busy = 1'b0;
  int               owner = -1;
  int               hold_cnt = 0;
  int               grants[$];
  int               poll_cnt = 0;

  int checks = 0;
  int fails  = 0;

  assign bus_req  = |dev_req;
  assign bus_busy = ext_busy || (owner >= 0) || (poll_en && dev_req[poll_addr]);

  arb_poll_top #(.N_MASTERS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_busy(bus_busy),
    .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode),
    .cfg_start_we(cfg_start_we), .cfg_start(cfg_start),
    .poll_en(poll_en), .poll_addr(poll_addr)
  );

  // Master models: a master grabs the bus when its address is polled,
  // holds busy for HOLD+1 cycles, then drops busy and its request
  always @(posedge clk) begin
    logic [2**AW-1:0] rel;
    rel = '0;
    if (owner >= 0) begin
      if (hold_cnt == 0) begin
        rel[owner] = 1'b1;
        owner <= -1;
      end else hold_cnt <= hold_cnt - 1;
    end else if (rst_n && poll_en && dev_req[poll_addr] && !ext_busy) begin
      owner    <= int'(poll_addr);
      hold_cnt <= HOLD;
      grants.push_back(int'(poll_addr));
    end
    dev_req <= (dev_req | req_post) & ~req_kill & ~rel;
    if (rst_n && poll_en) poll_cnt <= poll_cnt + 1;
  end

  // Behavioural reference model
  int m_state = 0;
  int m_addr = 0;
  int m_sweep = 0;
  int m_last = N - 1;
  int m_mode = 0;
  int m_start = 0;

  function automatic int start_of(int mode, int last, int sv);
    if (mode == 1) return (last + 1) % N;
    if (mode == 2) return (sv < N) ? sv : 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_addr <= 0; m_sweep <= 0; m_last <= N - 1;
      m_mode <= 0; m_start <= 0;
    end else begin
      case (m_state)
        0: if (bus_req && !bus_busy) begin
             m_state <= 1;
             m_addr  <= start_of(m_mode, m_last, m_start);
             m_sweep <= 0;
           end
        1: if (bus_busy) begin
             m_state <= 2; m_last <= m_addr;
           end else if (m_sweep == N - 1) m_state <= 0;
           else begin
             m_addr <= (m_addr + 1) % N; m_sweep <= m_sweep + 1;
           end
        default: if (!bus_busy) m_state <= 0;
      endcase
      if (cfg_mode_we)  m_mode  <= int'(cfg_mode);
      if (cfg_start_we) m_start <= int'(cfg_start);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(poll_en == (m_state == 1), "R2 poll_en vs model", int'(poll_en), int'(m_state == 1));
      check(int'(poll_addr) == m_addr, "R3 poll_addr vs model", int'(poll_addr), m_addr);
    end
  end

  task automatic post(input logic [2**AW-1:0] m);
    @(negedge clk); req_post = m;
    @(negedge clk); req_post = '0;
  endtask

  task automatic write_cfg(input int mode, input int sv);
    @(negedge clk);
    cfg_mode_we = 1'b1; cfg_mode = 2'(mode);
    cfg_start_we = 1'b1; cfg_start = AW'(sv);
    @(negedge clk);
    cfg_mode_we = 1'b0; cfg_start_we = 1'b0;
  endtask

  task automatic expect_grant(input int exp, input string tag);
    int n;
    n = 0;
    while (grants.size() == 0 && n < 300) begin
      @(negedge clk); n++;
    end
    if (grants.size() == 0) check(1'b0, tag, -1, exp);
    else begin
      int g;
      g = grants.pop_front();
      check(g == exp, tag, g, exp);
    end
  endtask

  task automatic settle();
    repeat (HOLD + 6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int snap;
    int seen;
    repeat (3) @(negedge clk);
    check(poll_en == 1'b0, "R1 reset poll_en", int'(poll_en), 0);
    check(poll_addr == '0, "R1 reset poll_addr", int'(poll_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(poll_en == 1'b0, "R1 idle without request", int'(poll_en), 0);

    // R5: fixed order from 0
    post(6'b101000);
    expect_grant(3, "R5 fixed first");
    expect_grant(5, "R5 fixed second");
    settle();
    post(6'b010001);
    expect_grant(0, "R5 fixed addr0");
    expect_grant(4, "R4 next after release");
    settle();

    // R6: rotating, last winner 4
    write_cfg(1, 0);
    post(6'b100100);
    expect_grant(5, "R6 rotate after 4");
    expect_grant(2, "R6 rotate wraps to 2");
    settle();
    post(6'b010011);
    expect_grant(4, "R6 rotate after 2");
    expect_grant(0, "R3 wrap 5 to 0");
    expect_grant(1, "R6 rotate after 0");
    settle();

    // R7: programmable start 3, then out-of-range start 7
    write_cfg(2, 3);
    post(6'b010010);
    expect_grant(4, "R7 prog start 3");
    expect_grant(1, "R7 prog wraps to 1");
    settle();
    write_cfg(2, 7);
    post(6'b000101);
    expect_grant(0, "R7 clamp start");
    expect_grant(2, "R7 clamp second");
    settle();

    // R10: code 3 behaves as fixed
    write_cfg(3, 4);
    post(6'b100010);
    expect_grant(1, "R10 code3 first");
    expect_grant(5, "R10 code3 second");
    settle();

    // R9: write in mid-sweep leaves the running sweep alone
    write_cfg(0, 0);
    snap = poll_cnt;
    post(6'b100000);
    @(negedge clk);
    write_cfg(2, 4);
    expect_grant(5, "R9 running sweep");
    check(poll_cnt - snap == 6, "R9 sweep from 0", poll_cnt - snap, 6);
    settle();
    post(6'b101000);
    expect_grant(5, "R9 new start applies");
    expect_grant(3, "R9 new start wraps");
    settle();

    // R8: request withdrawn at sweep start gives an empty sweep
    write_cfg(0, 0);
    snap = poll_cnt;
    @(negedge clk); req_post = 6'b000100;
    @(negedge clk); req_post = '0; req_kill = 6'b000100;
    @(negedge clk); req_kill = '0;
    repeat (12) @(negedge clk);
    check(poll_cnt - snap == N, "R8 empty sweep length", poll_cnt - snap, N);
    check(poll_en == 1'b0, "R8 back to idle", int'(poll_en), 0);
    check(grants.size() == 0, "R8 no owner", grants.size(), 0);

    // R2: external busy blocks polling in idle
    @(negedge clk); ext_busy = 1'b1;
    snap = poll_cnt;
    post(6'b000010);
    repeat (6) @(negedge clk);
    seen = poll_cnt - snap;
    check(seen == 0, "R2 no sweep while busy", seen, 0);
    ext_busy = 1'b0;
    expect_grant(1, "R2 sweep after busy drops");
    settle();

    finish_run();
  end
endmodule